// File: doc/BRIEF.md
# Display Output Channel Controller

This block is the control and status register file for three compositor output channels. Each channel feeds a pixel FIFO toward a display timing stage. Software programs each channel through a single-cycle register write port. It can set the active size, enable the channel, hold it in reset, or run it for exactly one frame. The block then tracks the channel through its idle, waiting-for-vertical-start and running phases, using pulses from the timing stage.

Underrun, end-of-line and end-of-frame events are caught in sticky flags in a shared status register, and software clears them by writing ones. Each flag has its own enable bit in the global control register, and the interrupt output is a registered OR of the enabled flags. A two-bit routing field selects which channel FIFO drives a fourth display output, and it has one code that disconnects that output.

Read data is combinational from the current register state. A write takes effect on the clock edge where `reg_we` is high. There is no back-pressure: every register access completes in its own cycle, and every event input is a one-cycle pulse.

Top module: `hvs_chan_regs`

## Requirements
- R1: After reset, every register reads zero except the following. The global control register reads 0x3000 (routing field = 3). Each channel status register reads 0x4: mode 0 (off) in bits 1:0, FIFO-empty in bit 2, FIFO-full in bit 3. `irq_o`, `out4_en_o`, `ch_active_o` and `ch_flush_o` are all low.
- R2: Channel control registers are at addresses 2, 3 and 4. Each holds width in bits 11:0, height in bits 23:12, one-shot in bit 29, reset in bit 30 and enable in bit 31. These fields read back as written, and bits 28:24 read as zero.
- R3: The reset bit of a channel stays set until software writes that channel's control register with bit 30 clear. It never clears by itself.
- R4: A channel is in mode 0 (off) when any of these holds: its reset bit is set, its enable bit is clear, or the master enable is clear. In mode 0 its status register, at address 5 + channel, reads FIFO-empty = 1 and FIFO-full = 0 whatever the FIFO inputs are. `ch_flush_o[c]` equals the reset bit.
- R5: The master enable is bit 0 of the global control register, at address 0. With master and channel enable set, the channel enters mode 1 (waiting) one cycle after leaving off. A `vstart_i` pulse moves it to mode 2 (running), where `ch_active_o` is high. In continuous mode an `eof_i` pulse returns it to mode 1.
- R6: A `uflow_i[c]` pulse sets bit c of the global status register (address 1), but only when channel c is not in mode 0.
- R7: Writing 1 to a global status bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle as a clearing write wins.
- R8: `irq_o` is the OR of (flag AND enable), registered, and appears one cycle after the flag. The enable bits are in the global control register: end-of-frame enables in bits 3:1, end-of-line enables in bits 6:4 and underrun enables in bits 9:7. They line up with status bits 5:3 (end-of-frame), 8:6 (end-of-line) and 2:0 (underrun).
- R9: The routing field is bits 13:12 of the global control register and drives `out4_src_o`. `out4_en_o` is high for values 0, 1 and 2 (FIFO 0, 1 or 2), and low for value 3.
- R10: In one-shot mode, an `eof_i` pulse while running clears the channel's enable bit and returns it to mode 0.
- R11: End-of-frame and end-of-line flags are set only while the channel is in mode 2.
- R12: Outside mode 0, the status FIFO-empty and FIFO-full bits follow `fifo_empty_i[c]` and `fifo_full_i[c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| vstart_i | input | 3 | Per-channel vertical-start pulse |
| eol_i | input | 3 | Per-channel end-of-line pulse |
| eof_i | input | 3 | Per-channel end-of-frame pulse |
| uflow_i | input | 3 | Per-channel FIFO underrun pulse |
| fifo_empty_i | input | 3 | Per-channel FIFO empty level |
| fifo_full_i | input | 3 | Per-channel FIFO full level |
| ch_active_o | output | 3 | Channel in running mode |
| ch_flush_o | output | 3 | Channel reset bit, flushes its FIFO |
| out4_en_o | output | 1 | Fourth output connected |
| out4_src_o | output | 2 | FIFO index routed to the fourth output |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The underrun path is swept over every combination of the three underrun enables against an event on each channel. This shows whether the interrupt follows the enable of the right channel rather than a neighbour's. Clear-by-write is swept over all eight clear patterns with every flag set, which separates a per-bit clear from a whole-register clear or an inverted mask. All four routing codes and all four FIFO-level combinations are applied, and the field readback uses patterns that differ in every field. Single-case tests cover the mode sequence, a one-shot frame, a channel held in reset, an underrun on a disabled channel, and a set event that collides with a clearing write. These show the ordering rules a sweep cannot reach.

// File: rtl/hvs_pkg.sv
package hvs_pkg;
  localparam int NCH    = 3;
  localparam int ADDR_W = $clog2(2 + 2 * NCH);
  localparam int NFLAG  = 3 * NCH;

  localparam logic [ADDR_W-1:0] A_GCTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_GSTAT = ADDR_W'(1);
  localparam int A_CTRL0 = 2;
  localparam int A_STAT0 = 2 + NCH;

  // global control bit layout
  localparam int GC_MASTER = 0;
  localparam int GC_EOF    = 1;
  localparam int GC_EOL    = 1 + NCH;
  localparam int GC_UF     = 1 + 2 * NCH;
  localparam int GC_MUX    = 12;

  // channel control bit layout
  localparam int CC_EN  = 31;
  localparam int CC_RST = 30;
  localparam int CC_ONE = 29;

  localparam logic [1:0] MUX_OFF = 2'd3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_RUN  = 2'd2
  } chmode_e;
endpackage

// File: rtl/hvs_chan_seq.sv
module hvs_chan_seq
  import hvs_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  input  logic             master_en,
  input  logic             vstart,
  input  logic             eof,
  output logic             en_q,
  output logic             rst_q,
  output logic             oneshot_q,
  output logic [DIM_W-1:0] width_q,
  output logic [DIM_W-1:0] height_q,
  output logic [1:0]       mode_o
);
  chmode_e mode_q, mode_d;
  logic    live, shot_done;

  assign live      = en_q && !rst_q && master_en;
  assign shot_done = live && (mode_q == MODE_RUN) && eof && oneshot_q;
  assign mode_o    = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      rst_q     <= 1'b0;
      oneshot_q <= 1'b0;
      width_q   <= '0;
      height_q  <= '0;
    end else if (wr_en) begin
      en_q      <= wdata[CC_EN];
      rst_q     <= wdata[CC_RST];
      oneshot_q <= wdata[CC_ONE];
      width_q   <= wdata[DIM_W-1:0];
      height_q  <= wdata[2*DIM_W-1:DIM_W];
    end else if (shot_done) begin
      en_q <= 1'b0;
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (!live) begin
      mode_d = MODE_OFF;
    end else begin
      case (mode_q)
        MODE_OFF:  mode_d = MODE_WAIT;
        MODE_WAIT: if (vstart) mode_d = MODE_RUN;
        MODE_RUN:  if (eof) mode_d = oneshot_q ? MODE_OFF : MODE_WAIT;
        default:   mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/hvs_irq_flags.sv
module hvs_irq_flags #(
  parameter int NF = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic          clr_we,
  input  logic [NF-1:0] clr_mask,
  input  logic [NF-1:0] en_vec,
  output logic [NF-1:0] flags_q,
  output logic          irq_o
);
  logic [NF-1:0] flags_d;

  always_comb begin
    flags_d = flags_q;
    if (clr_we) flags_d = flags_d & ~clr_mask;
    flags_d = flags_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_o   <= |(flags_q & en_vec);
    end
  end
endmodule

// File: rtl/hvs_chan_regs.sv
module hvs_chan_regs
  import hvs_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    vstart_i,
  input  logic [NCH-1:0]    eol_i,
  input  logic [NCH-1:0]    eof_i,
  input  logic [NCH-1:0]    uflow_i,
  input  logic [NCH-1:0]    fifo_empty_i,
  input  logic [NCH-1:0]    fifo_full_i,
  output logic [NCH-1:0]    ch_active_o,
  output logic [NCH-1:0]    ch_flush_o,
  output logic              out4_en_o,
  output logic [1:0]        out4_src_o,
  output logic              irq_o
);
  localparam int DIM2 = 2 * DIM_W;

  logic           master_q;
  logic [NCH-1:0] eof_en_q, eol_en_q, uf_en_q;
  logic [1:0]     mux_q;
  logic           wr_g, wr_s;

  logic [NCH-1:0]   en_v, rst_v, os_v, off_v;
  logic [DIM_W-1:0] w_v [NCH];
  logic [DIM_W-1:0] h_v [NCH];
  logic [2*NCH-1:0] mode_flat;
  logic [NCH-1:0]   uf_set, eof_set, eol_set;
  logic [NFLAG-1:0] flag_q;

  assign wr_g = reg_we && (reg_addr == A_GCTRL);
  assign wr_s = reg_we && (reg_addr == A_GSTAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      eof_en_q <= '0;
      eol_en_q <= '0;
      uf_en_q  <= '0;
      mux_q    <= MUX_OFF;
    end else if (wr_g) begin
      master_q <= reg_wdata[GC_MASTER];
      eof_en_q <= reg_wdata[GC_EOF +: NCH];
      eol_en_q <= reg_wdata[GC_EOL +: NCH];
      uf_en_q  <= reg_wdata[GC_UF +: NCH];
      mux_q    <= reg_wdata[GC_MUX +: 2];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0] mode_c;
    logic       wr_c;
    assign wr_c = reg_we && (reg_addr == ADDR_W'(A_CTRL0 + c));

    hvs_chan_seq #(.DIM_W(DIM_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_c),
      .wdata     (reg_wdata),
      .master_en (master_q),
      .vstart    (vstart_i[c]),
      .eof       (eof_i[c]),
      .en_q      (en_v[c]),
      .rst_q     (rst_v[c]),
      .oneshot_q (os_v[c]),
      .width_q   (w_v[c]),
      .height_q  (h_v[c]),
      .mode_o    (mode_c)
    );

    assign mode_flat[2*c +: 2] = mode_c;
    assign off_v[c]       = (mode_c == MODE_OFF);
    assign ch_active_o[c] = (mode_c == MODE_RUN);
    assign uf_set[c]      = uflow_i[c] && !off_v[c];
    assign eof_set[c]     = eof_i[c] && (mode_c == MODE_RUN);
    assign eol_set[c]     = eol_i[c] && (mode_c == MODE_RUN);
  end

  hvs_irq_flags #(.NF(NFLAG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  ({eol_set, eof_set, uf_set}),
    .clr_we   (wr_s),
    .clr_mask (reg_wdata[NFLAG-1:0]),
    .en_vec   ({eol_en_q, eof_en_q, uf_en_q}),
    .flags_q  (flag_q),
    .irq_o    (irq_o)
  );

  assign ch_flush_o = rst_v;
  assign out4_src_o = mux_q;
  assign out4_en_o  = (mux_q != MUX_OFF);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_GCTRL) begin
      reg_rdata[GC_MASTER]      = master_q;
      reg_rdata[GC_EOF +: NCH]  = eof_en_q;
      reg_rdata[GC_EOL +: NCH]  = eol_en_q;
      reg_rdata[GC_UF +: NCH]   = uf_en_q;
      reg_rdata[GC_MUX +: 2]    = mux_q;
    end else if (reg_addr == A_GSTAT) begin
      reg_rdata[NFLAG-1:0] = flag_q;
    end
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == ADDR_W'(A_CTRL0 + c)) begin
        reg_rdata[CC_EN]         = en_v[c];
        reg_rdata[CC_RST]        = rst_v[c];
        reg_rdata[CC_ONE]        = os_v[c];
        reg_rdata[DIM_W-1:0]     = w_v[c];
        reg_rdata[DIM2-1:DIM_W]  = h_v[c];
      end
      if (reg_addr == ADDR_W'(A_STAT0 + c)) begin
        reg_rdata[1:0] = mode_flat[2*c +: 2];
        reg_rdata[2]   = off_v[c] ? 1'b1 : fifo_empty_i[c];
        reg_rdata[3]   = off_v[c] ? 1'b0 : fifo_full_i[c];
      end
    end
  end
endmodule

// File: rtl/hvs_chan_regs_chk.sv
module hvs_chan_regs_chk
  import hvs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [NCH-1:0]    uflow_i,
  input logic [NCH-1:0]    ch_flush_o,
  input logic [NCH-1:0]    ch_active_o,
  input logic [1:0]        out4_src_o,
  input logic [NFLAG-1:0]  flags,
  input logic [2*NCH-1:0]  modes
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R3
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_flush_o[c] && !(reg_we && reg_addr == ADDR_W'(A_CTRL0 + c)) |=> ch_flush_o[c]);
    // R4
    flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_flush_o[c] |=> !ch_active_o[c]);
    // R6
    uflow_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uflow_i[c] && modes[2*c +: 2] == MODE_OFF && !flags[c] && !(reg_we && reg_addr == A_GSTAT)
      |=> !flags[c]);
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_f
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !(reg_we && reg_addr == A_GSTAT && reg_wdata[i]) |=> flags[i]);
  end

  // R9
  mux_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_GCTRL) |=> $stable(out4_src_o));
endmodule

bind hvs_chan_regs hvs_chan_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .uflow_i     (uflow_i),
  .ch_flush_o  (ch_flush_o),
  .ch_active_o (ch_active_o),
  .out4_src_o  (out4_src_o),
  .flags       (flag_q),
  .modes       (mode_flat)
);

// File: tb/tb_hvs_chan_regs.sv
module tb_hvs_chan_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  vstart_i = '0, eol_i = '0, eof_i = '0, uflow_i = '0;
  logic [2:0]  fifo_empty_i = 3'b111, fifo_full_i = 3'b000;
  logic [2:0]  ch_active_o, ch_flush_o;
  logic        out4_en_o, irq_o;
  logic [1:0]  out4_src_o;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hvs_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vstart_i(vstart_i),
    .eol_i(eol_i), .eof_i(eof_i), .uflow_i(uflow_i),
    .fifo_empty_i(fifo_empty_i), .fifo_full_i(fifo_full_i),
    .ch_active_o(ch_active_o), .ch_flush_o(ch_flush_o),
    .out4_en_o(out4_en_o), .out4_src_o(out4_src_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int kind, input int c);
    @(negedge clk);
    case (kind)
      0: vstart_i[c] = 1'b1;
      1: eof_i[c]    = 1'b1;
      2: eol_i[c]    = 1'b1;
      default: uflow_i[c] = 1'b1;
    endcase
    @(negedge clk);
    vstart_i = '0; eof_i = '0; eol_i = '0; uflow_i = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 gctrl", v, 32'h3000);
    rd(3'd1, v); chk("R1 gstat", v, 32'h0);
    for (int c = 0; c < 3; c++) begin
      rd(3'(2 + c), v); chk("R1 chctrl", v, 32'h0);
      rd(3'(5 + c), v); chk("R1 chstat", v, 32'h4);
    end
    chk("R1 outputs", {irq_o, out4_en_o, ch_active_o, ch_flush_o}, 32'h0);

    // R2 field readback sweep, master off
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [11:0] w, h;
        logic [31:0] d;
        w = 12'(k * 32'h5A3 + c * 7 + 1);
        h = ~w;
        d = {3'(k + c), 5'h1F, h, w};
        wr(3'(2 + c), d);
        rd(3'(2 + c), v); chk("R2 fields", v, d & 32'hE0FF_FFFF);
      end
      wr(3'(2 + c), 32'h0);
    end

    // R9 routing sweep
    for (int m = 0; m < 4; m++) begin
      wr(3'd0, 32'(m) << 12);
      @(negedge clk);
      chk("R9 src", {31'h0, out4_en_o}, (m != 3) ? 32'h1 : 32'h0);
      chk("R9 sel", {30'h0, out4_src_o}, 32'(m));
    end

    // R3 / R4 reset bit held, FIFO inputs ignored
    wr(3'd0, 32'h1);
    fifo_full_i = 3'b111; fifo_empty_i = 3'b000;
    wr(3'd3, 32'hC000_0000);
    repeat (5) @(negedge clk);
    rd(3'd3, v); chk("R3 reset held", v, 32'hC000_0000);
    chk("R4 flush out", {29'h0, ch_flush_o}, 32'h2);
    rd(3'd6, v); chk("R4 status in reset", v, 32'h4);
    rd(3'd5, v); chk("R4 status disabled", v, 32'h4);
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R3 reset cleared", v, 32'h0);
    chk("R4 flush clear", {29'h0, ch_flush_o}, 32'h0);

    // R12 FIFO level pass-through sweep on channel 0
    wr(3'd2, 32'h8000_0000);
    for (int p = 0; p < 4; p++) begin
      fifo_empty_i[0] = p[0]; fifo_full_i[0] = p[1];
      rd(3'd5, v); chk("R12 levels", v, 32'h1 | (32'(p) << 2));
    end
    fifo_empty_i = 3'b111; fifo_full_i = 3'b000;

    // R5 / R11 mode sequence on channel 2
    wr(3'd1, 32'h1FF);
    wr(3'd4, 32'h8000_0000);
    rd(3'd7, v); chk("R5 waiting", v, 32'h5);
    pulse(1, 2); pulse(2, 2);
    rd(3'd1, v); chk("R11 no flags while waiting", v, 32'h0);
    pulse(0, 2);
    chk("R5 active", {29'h0, ch_active_o}, 32'h4);
    rd(3'd7, v); chk("R5 running", v, 32'h6);
    pulse(2, 2);
    rd(3'd1, v); chk("R11 eol flag", v, 32'h100);
    pulse(1, 2);
    rd(3'd1, v); chk("R11 eof flag", v, 32'h120);
    rd(3'd7, v); chk("R5 back to wait", v, 32'h5);

    // R10 one-shot
    wr(3'd4, 32'hA000_0005);
    @(negedge clk);
    pulse(0, 2);
    rd(3'd7, v); chk("R10 running", v, 32'h6);
    pulse(1, 2);
    rd(3'd4, v); chk("R10 enable cleared", v, 32'h2000_0005);
    rd(3'd7, v); chk("R10 off", v, 32'h4);

    // R6 / R8 underrun sweep, all enable masks, channels 0..2
    for (int c = 0; c < 3; c++) wr(3'(2 + c), 32'h8000_0000);
    @(negedge clk);
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 3; c++) begin
        wr(3'd0, 32'h1 | (32'(m) << 7));
        wr(3'd1, 32'h1FF);
        @(negedge clk);
        chk("R8 idle irq", {31'h0, irq_o}, 32'h0);
        pulse(3, c);
        rd(3'd1, v); chk("R6 underrun flag", v, 32'h1 << c);
        chk("R8 irq gating", {31'h0, irq_o}, 32'((m >> c) & 1));
      end
    end

    // R6 underrun on a disabled channel is ignored
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h1FF);
    pulse(3, 1);
    rd(3'd1, v); chk("R6 disabled ignored", v, 32'h0);
    @(negedge clk);
    chk("R6 no irq", {31'h0, irq_o}, 32'h0);
    wr(3'd3, 32'h8000_0000);
    @(negedge clk);

    // R7 write-one-to-clear sweep
    for (int p = 0; p < 8; p++) begin
      wr(3'd1, 32'h1FF);
      @(negedge clk);
      uflow_i = 3'b111;
      @(negedge clk);
      uflow_i = 3'b000;
      wr(3'd1, 32'(p));
      rd(3'd1, v); chk("R7 w1c", v, 32'(7 & ~p));
    end

    // R7 set wins over a clearing write in the same cycle
    wr(3'd1, 32'h1FF);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h1; uflow_i = 3'b001;
    @(negedge clk);
    reg_we = 1'b0; uflow_i = 3'b000;
    rd(3'd1, v); chk("R7 set wins", v, 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog R1-all actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule